// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block decides whether a received CAN frame is kept and where it goes. When the protocol engine finishes a frame, it presents the identifier and the IDE bit together with a one-cycle strobe. The block compares that identifier against sixteen programmable filters. Each filter picks one of three shared masks, or exact matching. The block returns a verdict: accept or drop, which filter took the frame, and which receive buffer the frame is bound for. When every matching buffer still holds an unread message, it raises an overflow instead.

Several filters may point at different buffers for the same identifier. When the buffer of the first matching filter is still full, the frame falls over to the next matching filter whose buffer is empty. This lets a high-rate identifier rotate through buffers.

Filters and masks are loaded through a simple write port. That port works only while the block sits in its configuration state. A controller FSM has three states:
- `ST_CONFIG`: writes are accepted and frames are ignored.
- `ST_LISTEN`: the block waits for a frame.
- `ST_EVAL`: the block registers the verdict.

The FSM has five transitions:
- `ST_CONFIG` to `ST_LISTEN` when `cfg_mode` falls.
- `ST_LISTEN` to `ST_CONFIG` when `cfg_mode` rises.
- `ST_LISTEN` to `ST_EVAL` on an accepted strobe.
- `ST_EVAL` to `ST_LISTEN` always.
- Any state to `ST_CONFIG` on reset.

Top module: `can_accept_bank`

## Requirements
- R1: After reset, the block is in the configuration state, every filter and mask is zero (all filters disabled), and every result output is low.
- R2: A write to address 0..15 loads a filter entry with layout bit 36 enable, bit 35 EXIDE, bits 34:33 mask select, bits 32:29 destination buffer, bits 28:0 identifier. A write to address 16..18 loads mask 0..2, with bit 35 MIDE and bits 28:0 mask bits. A write is taken only on a clock edge where the block is in the configuration state; writes made in normal operation leave the bank unchanged.
- R3: A `frame_valid` strobe sampled in the listening state with `cfg_mode` low makes `res_valid` pulse high for exactly one cycle, two rising edges after the strobe. A strobe while in configuration produces no result.
- R4: A mask bit of 1 requires the identifier bit to equal the filter bit; a mask bit of 0 makes that bit don't-care.
- R5: For a standard frame (`frame_ide`=0) only identifier bits 28:18 (the 11-bit identifier) take part in comparison; bits 17:0 are ignored. For an extended frame all 29 bits take part.
- R6: When the selected mask has MIDE set, the frame IDE must equal the filter's EXIDE bit. With MIDE clear, both frame types can match.
- R7: Mask select value 3 means exact matching: all identifier bits are compared and IDE must equal EXIDE.
- R8: A filter whose enable bit is 0 never matches.
- R9: On acceptance, `res_accept`=1, `res_filter` is the lowest-numbered matching filter whose destination buffer is empty (`buf_full` bit 0), and `res_buffer` is that filter's destination.
- R10: A matching filter whose destination buffer is full is skipped in favour of the next matching filter with an empty buffer.
- R11: If at least one filter matches but all their buffers are full, `res_accept`=0 and `res_overflow`=1, and `res_filter`/`res_buffer` name the lowest-numbered matching filter and its buffer.
- R12: If no filter matches, `res_accept`, `res_overflow`, `res_filter` and `res_buffer` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | High requests the configuration state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address (filters 0..15, masks 16..18) |
| wr_data | input | 37 | Register write data |
| frame_valid | input | 1 | One-cycle strobe: a frame identifier is present |
| frame_id | input | 29 | Frame identifier; standard identifier in bits 28:18 |
| frame_ide | input | 1 | 0 standard frame, 1 extended frame |
| buf_full | input | 16 | Per-buffer flag: buffer holds an unread message |
| res_valid | output | 1 | One-cycle pulse: verdict outputs are fresh |
| res_accept | output | 1 | Frame accepted |
| res_overflow | output | 1 | Frame matched but every target buffer was full |
| res_filter | output | 4 | Index of the deciding filter |
| res_buffer | output | 4 | Destination buffer index |

## Verification
The bench loads a small bank that exercises every corner case:
- two filters with the same identifier and different buffers;
- a filter with low-order don't-care mask bits;
- a filter that accepts only frame types;
- an exact-match filter;
- a disabled filter.

It then sweeps identifiers, frame types and every pattern of full flags on the targeted buffers.

The following faults would each show up in the sweep:
- A design that ignored buffer-full flags would accept into an occupied buffer instead of falling over.
- A design that searched from the wrong end would report a higher filter index.
- A design that compared the low 18 bits of standard frames would reject standard frames carrying junk there.
- A design that ignored MIDE/EXIDE would let extended frames hit standard-only filters.

Directed checks cover writes made outside configuration and strobes made during configuration, each of which must leave no trace.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
    localparam int ID_W      = 29;
    localparam int SID_W     = 11;
    localparam int NUM_FLT   = 16;
    localparam int NUM_MSK   = 3;
    localparam int NUM_BUF   = 16;
    localparam int FLT_W     = $clog2(NUM_FLT);
    localparam int BUF_W     = $clog2(NUM_BUF);
    localparam int MSEL_W    = 2;
    localparam int ADDR_W    = 5;
    localparam int EXIDE_BIT = ID_W + BUF_W + MSEL_W;
    localparam int EN_BIT    = EXIDE_BIT + 1;
    localparam int DATA_W    = EN_BIT + 1;
    localparam int EXT_W     = ID_W - SID_W;
    localparam logic [MSEL_W-1:0] MSEL_EXACT = '1;

    typedef struct packed {
        logic              en;
        logic              exide;
        logic [MSEL_W-1:0] msel;
        logic [BUF_W-1:0]  dest;
        logic [ID_W-1:0]   id;
    } flt_t;

    typedef struct packed {
        logic            mide;
        logic [ID_W-1:0] bits;
    } msk_t;

    typedef enum logic [1:0] {
        ST_CONFIG = 2'd0,
        ST_LISTEN = 2'd1,
        ST_EVAL   = 2'd2
    } st_t;
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
    import can_flt_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_ok,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output flt_t [NUM_FLT-1:0]         flt_q,
    output msk_t [NUM_MSK-1:0]         msk_q
);
    for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flt_q[g] <= '0;
            else if (wr_ok && wr_en && wr_addr == ADDR_W'(g))
                flt_q[g] <= flt_t'(wr_data);
        end
    end

    for (genvar g = 0; g < NUM_MSK; g++) begin : g_msk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                msk_q[g] <= '0;
            else if (wr_ok && wr_en && wr_addr == ADDR_W'(NUM_FLT + g))
                msk_q[g] <= '{mide: wr_data[EXIDE_BIT], bits: wr_data[ID_W-1:0]};
        end
    end

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> ($stable(flt_q) && $stable(msk_q)));  // R2
endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
    import can_flt_pkg::*;
(
    input  flt_t [NUM_FLT-1:0] flt_q,
    input  msk_t [NUM_MSK-1:0] msk_q,
    input  logic [ID_W-1:0]    id,
    input  logic               ide,
    output logic [NUM_FLT-1:0] hit
);
    for (genvar g = 0; g < NUM_FLT; g++) begin : g_cmp
        msk_t            m;
        logic [ID_W-1:0] diff;
        logic            ide_ok;
        logic            h;

        always_comb begin
            if (flt_q[g].msel == MSEL_EXACT)
                m = '{mide: 1'b1, bits: '1};
            else
                m = msk_q[flt_q[g].msel];
            diff = (id ^ flt_q[g].id) & m.bits;
            if (!ide)
                diff[EXT_W-1:0] = '0;
            ide_ok = !m.mide || (ide == flt_q[g].exide);
            h = flt_q[g].en && (diff == '0) && ide_ok;
        end

        assign hit[g] = h;
    end
endmodule

// File: rtl/can_flt_pick.sv
module can_flt_pick
    import can_flt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_FLT-1:0] hit,
    input  flt_t [NUM_FLT-1:0] flt_q,
    input  logic [NUM_BUF-1:0] buf_full,
    output logic               acc,
    output logic               ovf,
    output logic [FLT_W-1:0]   f_idx,
    output logic [BUF_W-1:0]   b_idx
);
    logic             any_hit;
    logic             any_free;
    logic [FLT_W-1:0] first_idx;
    logic [FLT_W-1:0] free_idx;

    always_comb begin
        any_hit   = 1'b0;
        any_free  = 1'b0;
        first_idx = '0;
        free_idx  = '0;
        for (int i = NUM_FLT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit   = 1'b1;
                first_idx = FLT_W'(i);
                if (!buf_full[flt_q[i].dest]) begin
                    any_free = 1'b1;
                    free_idx = FLT_W'(i);
                end
            end
        end
    end

    always_comb begin
        acc   = 1'b0;
        ovf   = 1'b0;
        f_idx = '0;
        b_idx = '0;
        if (any_free) begin
            acc   = 1'b1;
            f_idx = free_idx;
            b_idx = flt_q[free_idx].dest;
        end else if (any_hit) begin
            ovf   = 1'b1;
            f_idx = first_idx;
            b_idx = flt_q[first_idx].dest;
        end
    end

    AST_ACCEPT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !buf_full[b_idx]);  // R10
    AST_ACCEPT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc || ovf) |-> hit[f_idx]);  // R9
endmodule

// File: rtl/can_accept_bank.sv
module can_accept_bank
    import can_flt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_mode,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               frame_valid,
    input  logic [ID_W-1:0]    frame_id,
    input  logic               frame_ide,
    input  logic [NUM_BUF-1:0] buf_full,
    output logic               res_valid,
    output logic               res_accept,
    output logic               res_overflow,
    output logic [FLT_W-1:0]   res_filter,
    output logic [BUF_W-1:0]   res_buffer
);
    st_t st_q, st_d;

    flt_t [NUM_FLT-1:0] flt_q;
    msk_t [NUM_MSK-1:0] msk_q;
    logic [NUM_FLT-1:0] hit;
    logic [ID_W-1:0]    cap_id;
    logic               cap_ide;
    logic               take;
    logic               p_acc, p_ovf;
    logic [FLT_W-1:0]   p_fi;
    logic [BUF_W-1:0]   p_bi;

    assign take = (st_q == ST_LISTEN) && !cfg_mode && frame_valid;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CONFIG: if (!cfg_mode) st_d = ST_LISTEN;
            ST_LISTEN: begin
                if (cfg_mode)         st_d = ST_CONFIG;
                else if (frame_valid) st_d = ST_EVAL;
            end
            ST_EVAL:   st_d = ST_LISTEN;
            default:   st_d = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CONFIG;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_id  <= '0;
            cap_ide <= 1'b0;
        end else if (take) begin
            cap_id  <= frame_id;
            cap_ide <= frame_ide;
        end
    end

    can_flt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (st_q == ST_CONFIG),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .flt_q   (flt_q),
        .msk_q   (msk_q)
    );

    can_flt_match u_match (
        .flt_q (flt_q),
        .msk_q (msk_q),
        .id    (cap_id),
        .ide   (cap_ide),
        .hit   (hit)
    );

    can_flt_pick u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .flt_q    (flt_q),
        .buf_full (buf_full),
        .acc      (p_acc),
        .ovf      (p_ovf),
        .f_idx    (p_fi),
        .b_idx    (p_bi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_accept   <= 1'b0;
            res_overflow <= 1'b0;
            res_filter   <= '0;
            res_buffer   <= '0;
        end else begin
            res_valid <= (st_q == ST_EVAL);
            if (st_q == ST_EVAL) begin
                res_accept   <= p_acc;
                res_overflow <= p_ovf;
                res_filter   <= p_fi;
                res_buffer   <= p_bi;
            end
        end
    end

    AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ##1 res_valid);  // R3
    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONFIG) |-> !res_valid);  // R3
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);  // R3
    AST_NO_OVERFLOW_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> !res_overflow);  // R11
endmodule

// File: tb/can_accept_bank_tb_top.sv
module can_accept_bank_tb_top;
    import can_flt_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_mode = 1'b1;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic               frame_valid = 1'b0;
    logic [ID_W-1:0]    frame_id = '0;
    logic               frame_ide = 1'b0;
    logic [NUM_BUF-1:0] buf_full = '0;
    logic               res_valid, res_accept, res_overflow;
    logic [FLT_W-1:0]   res_filter;
    logic [BUF_W-1:0]   res_buffer;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] sh_flt [NUM_FLT];
    logic [DATA_W-1:0] sh_msk [NUM_MSK];

    always #4 clk = ~clk;

    can_accept_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_valid(frame_valid), .frame_id(frame_id), .frame_ide(frame_ide),
        .buf_full(buf_full),
        .res_valid(res_valid), .res_accept(res_accept), .res_overflow(res_overflow),
        .res_filter(res_filter), .res_buffer(res_buffer)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] mkf(input logic en, input logic exide,
        input logic [1:0] msel, input logic [3:0] dest, input logic [ID_W-1:0] id);
        return {en, exide, msel, dest, id};
    endfunction

    function automatic logic [DATA_W-1:0] mkm(input logic mide, input logic [ID_W-1:0] bits);
        return {1'b0, mide, 2'b00, 4'h0, bits};
    endfunction

    function automatic logic [ID_W-1:0] sid(input logic [10:0] s, input logic [17:0] junk);
        return {s, junk};
    endfunction

    // expected {valid, accept, overflow, filter, buffer}
    function automatic logic [10:0] model(input logic [ID_W-1:0] id, input logic ide,
                                          input logic [NUM_BUF-1:0] full);
        int first = -1;
        int freef = -1;
        for (int f = 0; f < NUM_FLT; f++) begin
            logic [DATA_W-1:0] e = sh_flt[f];
            logic [ID_W-1:0] mb;
            logic mide, ok;
            if (e[34:33] == 2'd3) begin
                mb = '1; mide = 1'b1;
            end else begin
                mb = sh_msk[e[34:33]][28:0]; mide = sh_msk[e[34:33]][35];
            end
            if (ide) ok = (((id ^ e[28:0]) & mb) == 0);
            else     ok = (((id[28:18] ^ e[28:18]) & mb[28:18]) == 0);
            if (mide && (ide != e[35])) ok = 1'b0;
            if (!e[36]) ok = 1'b0;
            if (ok) begin
                if (first < 0) first = f;
                if (freef < 0 && !full[e[32:29]]) freef = f;
            end
        end
        if (freef >= 0) return {1'b1, 1'b1, 1'b0, 4'(freef), sh_flt[freef][32:29]};
        if (first >= 0) return {1'b1, 1'b0, 1'b1, 4'(first), sh_flt[first][32:29]};
        return {1'b1, 1'b0, 1'b0, 4'h0, 4'h0};
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic shadow);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (shadow) begin
            if (a < NUM_FLT) sh_flt[a] = d;
            else             sh_msk[a - NUM_FLT] = d;
        end
    endtask

    task automatic frame(input logic [ID_W-1:0] id, input logic ide,
                         output logic [10:0] got);
        frame_valid = 1'b1; frame_id = id; frame_ide = ide;
        @(negedge clk);
        frame_valid = 1'b0;
        @(negedge clk);
        got = {res_valid, res_accept, res_overflow, res_filter, res_buffer};
    endtask

    task automatic run_chk(input string req, input logic [ID_W-1:0] id, input logic ide,
                           input logic [10:0] exp);
        logic [10:0] got;
        frame(id, ide, got);
        chk(req, 32'(got), 32'(exp));
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] got;
        logic [ID_W-1:0] ids [10];
        logic [3:0] bsel [4];
        for (int i = 0; i < NUM_FLT; i++) sh_flt[i] = '0;
        for (int i = 0; i < NUM_MSK; i++) sh_msk[i] = '0;

        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        chk("R1", 32'({res_valid, res_accept, res_overflow, res_filter, res_buffer}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(res_valid), 32'h0);

        // R1: with the bank empty, no frame is accepted
        cfg_mode = 1'b0;
        @(negedge clk);
        run_chk("R1", sid(11'h123, 18'h0), 1'b0, 11'b1_0_0_0000_0000);
        run_chk("R12", {11'h123, 18'h2ABCD}, 1'b1, 11'b1_0_0_0000_0000);

        // configure
        cfg_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(5'd16, mkm(1'b1, '1), 1'b1);
        wr(5'd17, mkm(1'b0, {11'h7F0, 18'h0}), 1'b1);
        wr(5'd18, mkm(1'b1, '0), 1'b1);
        wr(5'd0, mkf(1, 0, 2'd0, 4'd1, sid(11'h123, 18'h0)), 1'b1);
        wr(5'd1, mkf(1, 1, 2'd0, 4'd2, 29'h1234568), 1'b1);
        wr(5'd2, mkf(1, 0, 2'd1, 4'd3, sid(11'h120, 18'h0)), 1'b1);
        wr(5'd3, mkf(1, 0, 2'd0, 4'd4, sid(11'h123, 18'h0)), 1'b1);
        wr(5'd4, mkf(0, 0, 2'd3, 4'd5, sid(11'h555, 18'h0)), 1'b1);
        wr(5'd5, mkf(1, 1, 2'd2, 4'd6, 29'h0), 1'b1);
        wr(5'd6, mkf(1, 0, 2'd3, 4'd7, sid(11'h2AA, 18'h0)), 1'b1);

        // R3: a strobe during configuration gives no result
        frame(sid(11'h123, 18'h0), 1'b0, got);
        chk("R3", 32'(got[10]), 32'h0);

        cfg_mode = 1'b0;
        @(negedge clk);

        // R2: write in normal operation is ignored (would enable filter 4)
        wr(5'd4, mkf(1, 0, 2'd3, 4'd5, sid(11'h555, 18'h0)), 1'b0);
        run_chk("R2", sid(11'h555, 18'h0), 1'b0, 11'b1_0_0_0000_0000);
        // R8: disabled filter 4 never matches
        run_chk("R8", sid(11'h555, 18'h1), 1'b0, 11'b1_0_0_0000_0000);

        // R3: pulse lasts one cycle
        frame(sid(11'h123, 18'h0), 1'b0, got);
        chk("R3", 32'(got[10]), 32'h1);
        @(negedge clk);
        chk("R3", 32'(res_valid), 32'h0);

        // R4: low four bits don't-care on filter 2
        run_chk("R4", sid(11'h12F, 18'h0), 1'b0, {3'b110, 4'd2, 4'd3});
        // R5: standard frame ignores the low 18 bits
        run_chk("R5", sid(11'h123, 18'h3A5A5), 1'b0, {3'b110, 4'd0, 4'd1});
        run_chk("R9", 29'h1234568, 1'b1, {3'b110, 4'd1, 4'd2});
        // R6: extended frame skips standard-only filter 0; MIDE clear on filter 2 admits it
        run_chk("R6", sid(11'h123, 18'h0), 1'b1, {3'b110, 4'd2, 4'd3});
        // R7: exact filter 6 takes standard 0x2AA; extended form falls to filter 5
        run_chk("R7", sid(11'h2AA, 18'h0), 1'b0, {3'b110, 4'd6, 4'd7});
        run_chk("R7", sid(11'h2AA, 18'h0), 1'b1, {3'b110, 4'd5, 4'd6});

        // R10: fall-over
        buf_full = 16'h0002;
        run_chk("R10", sid(11'h123, 18'h0), 1'b0, {3'b110, 4'd2, 4'd3});
        buf_full = 16'h000A;
        run_chk("R10", sid(11'h123, 18'h0), 1'b0, {3'b110, 4'd3, 4'd4});
        // R11: all targets full
        buf_full = 16'h001A;
        run_chk("R11", sid(11'h123, 18'h0), 1'b0, {3'b101, 4'd0, 4'd1});
        buf_full = '0;

        // sweep
        ids[0] = sid(11'h123, 18'h0);     ids[1] = sid(11'h123, 18'h15A5A);
        ids[2] = sid(11'h120, 18'h0);     ids[3] = sid(11'h12F, 18'h3FFFF);
        ids[4] = sid(11'h124, 18'h0);     ids[5] = sid(11'h2AA, 18'h0);
        ids[6] = 29'h1234568;             ids[7] = 29'h1234569;
        ids[8] = sid(11'h555, 18'h0);     ids[9] = 29'h0;
        bsel[0] = 4'd1; bsel[1] = 4'd3; bsel[2] = 4'd4; bsel[3] = 4'd6;
        for (int p = 0; p < 16; p++) begin
            logic [NUM_BUF-1:0] fl = '0;
            for (int b = 0; b < 4; b++) if (p[b]) fl[bsel[b]] = 1'b1;
            fl[2] = p[0] ^ p[3];
            buf_full = fl;
            for (int i = 0; i < 10; i++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [10:0] exp;
                    exp = model(ids[i], e[0], fl);
                    frame(ids[i], e[0], got);
                    chk(exp[9] ? "R9" : (exp[8] ? "R11" : "R12"), 32'(got), 32'(exp));
                end
            end
        end
        buf_full = '0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule